// File: doc/BRIEF.md
# Magnitude-Compare Associative Memory Array

This block is a content-addressable store of 32 words of 32 bits. Each cell has its own comparator, and all cells are compared in parallel against a held search argument. Each comparator reports whether the stored word is equal to, greater than, or less than the argument. There is no bit mask. A caller narrows a search by picking which of the three relations to act on.

A single command port carries an operation code, a relation code, an address and a data word. The operations are addressed write, addressed read, argument load, search, associative read and associative write. A search registers a per-cell response vector together with a count of responding cells. The count comes from an adder tree, so it costs one cycle. An associative write broadcasts one data word into every valid cell that meets the chosen relation. An associative read returns the bitwise OR of all such cells, which is the value a shared wired-OR bus would carry.

Top module: `magcam_array`

## Requirements
- R1: After reset, rd_data, rd_valid, resp_vec and resp_count are all zero, the argument is zero, and every cell is invalid, so an addressed read of any cell returns zero.
- R2: An addressed write (cmd_op 1) stores cmd_wdata in cell cmd_addr and marks that cell valid. No other cell changes.
- R3: An addressed read (cmd_op 2) sets rd_data one cycle later to the addressed cell's word, or to zero if that cell is invalid. rd_valid is high in that cycle only. Only the addressed cell drives the read path.
- R4: The argument load (cmd_op 3) stores cmd_wdata as the search argument. Comparison is unsigned, and "greater" means the stored word exceeds the argument.
- R5: A search (cmd_op 4) sets resp_vec one cycle later. Bit i is 1 when cell i is valid and meets the relation selected by cmd_rel: 00 is equal, 01 is greater, 10 is less, and 11 is none, which always gives zero.
- R6: resp_count equals the number of ones in resp_vec and changes in the same cycle.
- R7: A cell's comparison reflects a newly written word from the very next cycle. A search issued directly after a write sees the new value.
- R8: An associative write (cmd_op 6) stores cmd_wdata into every valid cell that meets the cmd_rel relation against the argument. Invalid cells and non-matching cells keep their contents, and relation 11 writes nothing.
- R9: An associative read (cmd_op 5) sets rd_data one cycle later to the bitwise OR of the words of all valid cells that meet cmd_rel, or zero if none meet it. rd_valid pulses for that cycle.
- R10: When cmd_valid is low, or when cmd_op is 0 or 7, no cell, argument or output register changes, except that rd_valid returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (see R2 to R10) |
| cmd_rel | input | 2 | Relation selector: 00 equal, 01 greater, 10 less, 11 none |
| cmd_addr | input | 5 | Cell index for addressed operations |
| cmd_wdata | input | 32 | Write data or argument value |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| resp_vec | output | 32 | Registered per-cell search response |
| resp_count | output | 6 | Number of responding cells |

## Verification
The hardest case to reach is the interaction between the valid bits and the relation logic. Cells that were never written must stay silent for every relation, even when their unwritten contents could happen to compare favourably. An associative write must also leave them untouched. The stimulus therefore fills only part of the array, including duplicate words and both extreme values. It then sweeps every relation code against several arguments that sit below, inside and above the stored range. A write followed at once by a search exercises the timing of R7.

// File: rtl/magcam_pkg.sv
package magcam_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_WR   = 3'd1,
    OP_RD   = 3'd2,
    OP_ARG  = 3'd3,
    OP_SRCH = 3'd4,
    OP_ARD  = 3'd5,
    OP_AWR  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    REL_EQ   = 2'd0,
    REL_GT   = 2'd1,
    REL_LT   = 2'd2,
    REL_NONE = 2'd3
  } rel_e;
endpackage

// File: rtl/magcam_cell.sv
module magcam_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] arg,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         valid,
  output logic         is_eq,
  output logic         is_gt,
  output logic         is_lt
);
  logic [W-1:0] word_q;
  logic         valid_q, valid_d;

  always_comb valid_d = valid_q | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) word_q <= wr_data;
  end

  assign valid   = valid_q;
  assign is_eq   = (word_q == arg);
  assign is_gt   = (word_q >  arg);
  assign is_lt   = (word_q <  arg);
  assign rd_data = (rd_en && valid_q) ? word_q : '0;

  AST_WR_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid); // R2
  AST_REL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $onehot({is_eq, is_gt, is_lt})); // R4
endmodule

// File: rtl/magcam_popcount.sv
module magcam_popcount #(
  parameter  int N  = 32,
  localparam int OW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [OW-1:0] total
);
  generate
    if (N == 1) begin : g_leaf
      assign total = bits;
    end else begin : g_split
      localparam int L  = N / 2;
      localparam int R  = N - L;
      localparam int LW = $clog2(L + 1);
      localparam int RW = $clog2(R + 1);
      logic [LW-1:0] lo_sum;
      logic [RW-1:0] hi_sum;
      magcam_popcount #(.N(L)) u_lo (.bits(bits[L-1:0]), .total(lo_sum));
      magcam_popcount #(.N(R)) u_hi (.bits(bits[N-1:L]), .total(hi_sum));
      assign total = OW'(lo_sum) + OW'(hi_sum);
    end
  endgenerate
endmodule

// File: rtl/magcam_array.sv
module magcam_array
  import magcam_pkg::*;
#(
  parameter  int WORDS = 32,
  parameter  int WIDTH = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int CW    = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [1:0]       cmd_rel,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_wdata,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic [WORDS-1:0] resp_vec,
  output logic [CW-1:0]    resp_count
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  op_e  op;
  rel_e rel;
  assign op  = op_e'(cmd_op);
  assign rel = rel_e'(cmd_rel);

  logic [WIDTH-1:0] arg_q, arg_d;
  logic [WIDTH-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;
  logic [WORDS-1:0] vec_q, vec_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  logic [WORDS-1:0] c_valid, c_eq, c_gt, c_lt, rel_hit, cell_we, rd_sel;
  logic [WIDTH-1:0] cell_rd [WORDS];
  logic [WIDTH-1:0] rd_or;
  logic [CW-1:0]    hit_cnt;

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_cell
      always_comb begin
        unique case (rel)
          REL_EQ:  rel_hit[i] = c_valid[i] & c_eq[i];
          REL_GT:  rel_hit[i] = c_valid[i] & c_gt[i];
          REL_LT:  rel_hit[i] = c_valid[i] & c_lt[i];
          default: rel_hit[i] = 1'b0;
        endcase
        cell_we[i] = cmd_valid & (((op == OP_WR) & (cmd_addr == AW'(i))) |
                                  ((op == OP_AWR) & rel_hit[i]));
        rd_sel[i]  = cmd_valid & (((op == OP_RD) & (cmd_addr == AW'(i))) |
                                  ((op == OP_ARD) & rel_hit[i]));
      end

      magcam_cell #(.W(WIDTH)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .wr_en   (cell_we[i]),
        .wr_data (cmd_wdata),
        .arg     (arg_q),
        .rd_en   (rd_sel[i]),
        .rd_data (cell_rd[i]),
        .valid   (c_valid[i]),
        .is_eq   (c_eq[i]),
        .is_gt   (c_gt[i]),
        .is_lt   (c_lt[i])
      );
    end
  endgenerate

  always_comb begin
    rd_or = '0;
    for (int i = 0; i < WORDS; i++) rd_or = rd_or | cell_rd[i];
  end

  magcam_popcount #(.N(WORDS)) u_count (.bits(rel_hit), .total(hit_cnt));

  always_comb begin
    arg_d    = arg_q;
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    vec_d    = vec_q;
    cnt_d    = cnt_q;
    if (cmd_valid) begin
      unique case (op)
        OP_ARG:  arg_d = cmd_wdata;
        OP_RD, OP_ARD: begin
          rdata_d  = rd_or;
          rvalid_d = 1'b1;
        end
        OP_SRCH: begin
          vec_d = rel_hit;
          cnt_d = hit_cnt;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      arg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      vec_q    <= '0;
      cnt_q    <= '0;
    end else begin
      arg_q    <= arg_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      vec_q    <= vec_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rd_data    = rdata_q;
  assign rd_valid   = rvalid_q;
  assign resp_vec   = vec_q;
  assign resp_count = cnt_q;

  AST_RD_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && op == OP_RD) |-> $onehot0(rd_sel)); // R3
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_valid |-> $past(cmd_valid && (op == OP_RD || op == OP_ARD))); // R3
  AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && op == OP_SRCH && rel == REL_NONE) |=> (resp_vec == '0)); // R5
  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n_int)
    resp_count == CW'($countones(resp_vec))); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cmd_valid |-> (cell_we == '0)); // R10
endmodule

// File: tb/test_magcam_array.sv
module test_magcam_array;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_rel;
  logic [4:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [31:0] resp_vec;
  logic [5:0]  resp_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] m_word [N];
  bit          m_vld  [N];
  logic [31:0] m_arg;

  always #(CLK_PERIOD / 2) clk = ~clk;

  magcam_array i_magcam_array (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rel(cmd_rel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .resp_vec(resp_vec),
    .resp_count(resp_count)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] rel, input int addr,
                        input logic [31:0] d, input logic v = 1'b1);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_rel = rel; cmd_addr = 5'(addr); cmd_wdata = d;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i % 4) << 30) | 32'((i * 5) % 8);
  endfunction

  function automatic bit hit(input logic [31:0] w, input logic [31:0] a, input int rel);
    case (rel)
      0: return w == a;
      1: return w > a;
      2: return w < a;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int rel);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_vld[i] && hit(m_word[i], m_arg, rel);
    return v;
  endfunction

  function automatic logic [31:0] exp_or(input int rel);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) if (m_vld[i] && hit(m_word[i], m_arg, rel)) v |= m_word[i];
    return v;
  endfunction

  function automatic int ones(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    do_cmd(3'd1, 2'd0, a, d);
    m_word[a] = d; m_vld[a] = 1'b1;
  endtask

  task automatic read_check(input int a, input string req);
    logic [31:0] e;
    do_cmd(3'd2, 2'd0, a, '0);
    e = m_vld[a] ? m_word[a] : 32'h0;
    check(rd_data == e && rd_valid, req, rd_data, e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] args [5];
    logic [31:0] e;
    args = '{32'h0, 32'hFFFF_FFFF, pat(5), 32'h8000_0004, pat(0)};
    for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_word[i] = '0; end
    m_arg = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_rel = '0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(rd_data == 0, "R1 rd_data", rd_data, 0);
    check(rd_valid == 0, "R1 rd_valid", 32'(rd_valid), 0);
    check(resp_vec == 0, "R1 resp_vec", resp_vec, 0);
    check(resp_count == 0, "R1 resp_count", 32'(resp_count), 0);
    read_check(0, "R1 read invalid");
    do_cmd(3'd4, 2'd0, 0, '0);  // R1: argument 0 with no valid cells -> no response
    check(resp_vec == 0, "R1 empty search", resp_vec, 0);

    // R2: fill part of the array, including duplicates and extremes
    for (int i = 0; i < 24; i++) wr(i, pat(i));
    wr(31, 32'hFFFF_FFFF);
    wr(24, 32'h0);
    for (int i = 0; i < N; i++) read_check(i, "R2 R3 readback");
    do_cmd(3'd4, 2'd3, 0, '0);
    check(rd_valid == 0, "R3 rd_valid pulse", 32'(rd_valid), 0);

    // R4 R5 R6: sweep arguments and relations
    foreach (args[k]) begin
      do_cmd(3'd3, 2'd0, 0, args[k]);
      m_arg = args[k];
      for (int rel = 0; rel < 4; rel++) begin
        do_cmd(3'd4, 2'(rel), 0, '0);
        e = exp_vec(rel);
        check(resp_vec == e, "R4 R5 resp_vec", resp_vec, e);
        check(int'(resp_count) == ones(e), "R6 resp_count", 32'(resp_count), 32'(ones(e)));
      end
      // R9: associative read
      for (int rel = 0; rel < 4; rel++) begin
        do_cmd(3'd5, 2'(rel), 0, '0);
        e = exp_or(rel);
        check(rd_data == e && rd_valid, "R9 assoc read", rd_data, e);
      end
    end

    // R7: search directly after a write
    do_cmd(3'd3, 2'd0, 0, 32'h1234_5678);
    m_arg = 32'h1234_5678;
    wr(26, 32'h1234_5678);
    do_cmd(3'd4, 2'd0, 0, '0);
    e = exp_vec(0);
    check(resp_vec == e && resp_vec[26], "R7 immediate compare", resp_vec, e);

    // R8: associative write into the cells below the argument
    do_cmd(3'd3, 2'd0, 0, 32'h8000_0000);
    m_arg = 32'h8000_0000;
    do_cmd(3'd6, 2'd2, 0, 32'hA5A5_0000);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && hit(m_word[i], m_arg, 2)) m_word[i] = 32'hA5A5_0000;
    for (int i = 0; i < N; i++) read_check(i, "R8 assoc write");
    do_cmd(3'd6, 2'd3, 0, 32'h0BAD_0BAD);
    read_check(1, "R8 rel none writes nothing");
    read_check(28, "R8 invalid cell untouched");

    // R10: idle strobe, opcodes 0 and 7
    do_cmd(3'd1, 2'd0, 2, 32'hDEAD_BEEF, 1'b0);
    do_cmd(3'd7, 2'd0, 2, 32'hDEAD_BEEF);
    do_cmd(3'd0, 2'd0, 2, 32'hDEAD_BEEF);
    check(rd_valid == 0, "R10 no read pulse", 32'(rd_valid), 0);
    read_check(2, "R10 cell unchanged");
    do_cmd(3'd3, 2'd0, 0, 32'h5555_5555, 1'b0);
    do_cmd(3'd4, 2'd0, 0, '0);
    e = exp_vec(0);
    check(resp_vec == e, "R10 argument unchanged", resp_vec, e);

    finish_run();
  end
endmodule